// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog built around a 32-bit down-counter. Software programs a reload value and starts the count by setting the enable bit in the control word. From then on the count must be refreshed by writing a 16-bit key to the restart word. If the count runs out, the block raises a one-cycle expiry event and stops. Depending on the control bits it can also hold an interrupt line or drive a timed reset pulse on an external pin.

Each count step is either one system clock or one slow tick. The slow tick is the system clock divided by a parameter, which is 24 by default so that a 24 MHz clock gives a 1 MHz tick. The reset-pulse register holds the pulse length in slow ticks. It also holds the pin's polarity and drive mode, and these two bits change only when a recognised key byte is written in the top byte of the word. A variant parameter sets the width of the length field and decides whether the key byte is honoured at all.

Every access is a full aligned 32-bit word, and the two low address bits are ignored. A read returns its data in a register one clock after the read strobe.

Top module: `wdog_keyed_top`

## Requirements
- R1: After reset, the status word (word offset 0x00) and the reload word (0x04) read 0x03EF1480, the control word (0x0C) reads 0, and the pulse word (0x18) reads 0x000000FF.
- R2: Reads of the restart word (0x08), of the reserved words 0x10 and 0x14, and of any unmapped offset return 0. Writes to those offsets and to the status word change nothing.
- R3: A write to 0x08 whose low 16 bits are 0x4755 copies the reload value into the counter, and re-arms counting if the block is enabled. Any other value is ignored.
- R4: A control write is stored only when its bit 0 differs from the stored enable bit. A 0-to-1 write loads the counter from the reload value and starts counting. Bit 1 asks for a reset pulse, bit 2 for an interrupt, and bit 4 selects the slow tick. Bits 3 and 5 are stored and read back.
- R5: A 1-to-0 control write stores the value and freezes the counter at its present value.
- R6: With bit 4 clear, the counter steps once per clock. With bit 4 set, it steps once every TICK_DIV clocks, with the divider restarted at each arm. The first expiry therefore comes (reload+1)×step clocks after the arming write.
- R7: A step taken while the counter is 0 raises `expired_o` for exactly one cycle and stops counting. The counter then stays 0 until the block is re-armed.
- R8: If control bit 2 is set at expiry, `irq_o` rises one clock later and stays high until a valid restart key or a disable write.
- R9: If control bit 1 is set at expiry and the length field W is nonzero, the reset pin is asserted for W×TICK_DIV clocks, starting one clock after the expiry. If bit 1 is clear, the pin stays idle.
- R10: In the pulse word, key byte 0xA5 sets bit 31 (active-high), 0x5A clears it, 0xA8 sets bit 30 (push-pull) and 0x8A clears it. Any other nonzero key leaves both bits alone. The asserted pin level equals bit 31 and the idle level is its inverse. `rst_oe_o` is always 1 when push-pull and follows the asserted state when open-drain.
- R11: The writable length field is 20 bits when NEWER_VARIANT=1 and 8 bits when it is 0. With NEWER_VARIANT=0, key bytes are ignored and bits 31:30 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe |
| rd_en | input | 1 | Word read strobe |
| addr | input | ADDR_W | Byte address (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| expired_o | output | 1 | One-cycle expiry event |
| irq_o | output | 1 | Sticky expiry interrupt |
| rst_pin_o | output | 1 | Reset pin level |
| rst_oe_o | output | 1 | Reset pin output enable |

## Verification
The bench builds two instances from the same bus. The main one uses NEWER_VARIANT=1 and TICK_DIV=4, so the slow tick and multi-tick reset pulses fit within a few dozen clocks. The second uses NEWER_VARIANT=0, which exposes the 8-bit length field and the ignored key bytes. Small reload values programmed through the bus bring expiry, re-arming after expiry and the frozen counter after a disable within easy reach.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // word indices (byte offset / 4)
  localparam int WIDX_STATUS  = 0;
  localparam int WIDX_RELOAD  = 1;
  localparam int WIDX_RESTART = 2;
  localparam int WIDX_CTRL    = 3;
  localparam int WIDX_PULSE   = 6;

  localparam logic [15:0] RESTART_KEY = 16'h4755;
  localparam logic [7:0]  KEY_POL_HI  = 8'hA5;
  localparam logic [7:0]  KEY_POL_LO  = 8'h5A;
  localparam logic [7:0]  KEY_PP      = 8'hA8;
  localparam logic [7:0]  KEY_OD      = 8'h8A;

  localparam int CTRL_W  = 6;
  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_SLOW = 4;

  localparam int PB_POLHI = 31;
  localparam int PB_PP    = 30;

  typedef struct packed {
    logic load;     // copy reload into counter
    logic arm;      // counting runs after the load
    logic stop;     // enable fell
    logic clr_irq;  // valid key or disable
  } wdog_cmd_t;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int          ADDR_W        = 8,
  parameter bit          NEWER_VARIANT = 1'b1,
  parameter int          FIELD_W       = 20,
  parameter logic [31:0] RESET_RELOAD  = 32'h03EF1480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [31:0]       cnt_i,
  output logic [31:0]       rdata,
  output logic [31:0]       reload_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [31:0]       width_o,
  output wdog_cmd_t         cmd_o
);
  localparam int          WIDX_W     = ADDR_W - 2;
  localparam logic [31:0] FIELD_MASK = 32'((64'd1 << FIELD_W) - 64'd1);

  logic [WIDX_W-1:0] widx;
  logic              unused_lsb;
  logic              sel_reload, sel_restart, sel_ctrl, sel_pulse;
  logic              key_ok, en_rise, en_fall;
  logic [31:0]       reload_q, width_q, width_nx;
  logic [CTRL_W-1:0] ctrl_q;
  logic [7:0]        key_byte;

  assign widx       = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  assign sel_reload  = wr_en && (widx == WIDX_W'(WIDX_RELOAD));
  assign sel_restart = wr_en && (widx == WIDX_W'(WIDX_RESTART));
  assign sel_ctrl    = wr_en && (widx == WIDX_W'(WIDX_CTRL));
  assign sel_pulse   = wr_en && (widx == WIDX_W'(WIDX_PULSE));

  assign key_ok  = sel_restart && (wdata[15:0] == RESTART_KEY);
  assign en_rise = sel_ctrl &&  wdata[CB_EN] && !ctrl_q[CB_EN];
  assign en_fall = sel_ctrl && !wdata[CB_EN] &&  ctrl_q[CB_EN];

  always_comb begin
    cmd_o.load    = key_ok || en_rise;
    cmd_o.arm     = en_rise || (key_ok && ctrl_q[CB_EN]);
    cmd_o.stop    = en_fall;
    cmd_o.clr_irq = key_ok || en_fall;
  end

  assign key_byte = wdata[31:24];

  always_comb begin
    width_nx = width_q;
    if (NEWER_VARIANT && key_byte != 8'h00) begin
      case (key_byte)
        KEY_POL_HI: width_nx[PB_POLHI] = 1'b1;
        KEY_POL_LO: width_nx[PB_POLHI] = 1'b0;
        KEY_PP:     width_nx[PB_PP]    = 1'b1;
        KEY_OD:     width_nx[PB_PP]    = 1'b0;
        default:    ;
      endcase
    end
    width_nx = (width_nx & ~FIELD_MASK) | (wdata & FIELD_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= RESET_RELOAD;
      ctrl_q   <= '0;
      width_q  <= 32'h0000_00FF;
    end else begin
      if (sel_reload) reload_q <= wdata;
      if (en_rise || en_fall) ctrl_q <= wdata[CTRL_W-1:0];
      if (sel_pulse) width_q <= width_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (widx)
        WIDX_W'(WIDX_STATUS): rdata <= cnt_i;
        WIDX_W'(WIDX_RELOAD): rdata <= reload_q;
        WIDX_W'(WIDX_CTRL):   rdata <= {{(32-CTRL_W){1'b0}}, ctrl_q};
        WIDX_W'(WIDX_PULSE):  rdata <= width_q;
        default:              rdata <= '0;
      endcase
    end
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
  assign width_o  = width_q;
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int          TICK_DIV     = 24,
  parameter logic [31:0] RESET_RELOAD = 32'h03EF1480
) (
  input  logic        clk,
  input  logic        rst,
  input  wdog_cmd_t   cmd_i,
  input  logic [31:0] reload_i,
  input  logic        slow_i,
  output logic [31:0] cnt_o,
  output logic        run_o,
  output logic        expired_o
);
  localparam int PS_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PS_W-1:0] ps_q;
  logic [31:0]     cnt_q;
  logic            run_q, exp_q, ps_last, step;

  assign ps_last = (ps_q == PS_W'(TICK_DIV - 1));
  assign step    = slow_i ? ps_last : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RESET_RELOAD;
      run_q <= 1'b0;
      ps_q  <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (cmd_i.stop) begin
        run_q <= 1'b0;
      end else if (cmd_i.load) begin
        cnt_q <= reload_i;
        ps_q  <= '0;
        run_q <= cmd_i.arm;
      end else if (run_q) begin
        ps_q <= ps_last ? '0 : ps_q + 1'b1;
        if (step) begin
          if (cnt_q == 32'd0) begin
            exp_q <= 1'b1;
            run_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 32'd1;
          end
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign run_o     = run_q;
  assign expired_o = exp_q;
endmodule

// File: rtl/wdog_action.sv
module wdog_action #(
  parameter int TICK_DIV = 24,
  parameter int FIELD_W  = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               expired_i,
  input  logic               want_rst_i,
  input  logic               want_irq_i,
  input  logic               clr_irq_i,
  input  logic               pol_hi_i,
  input  logic               push_pull_i,
  input  logic [FIELD_W-1:0] len_i,
  output logic               irq_o,
  output logic               pin_o,
  output logic               oe_o
);
  localparam int PS_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PS_W-1:0]    ps_q;
  logic [FIELD_W-1:0] rem_q;
  logic               act_q, irq_q, ps_last;

  assign ps_last = (ps_q == PS_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      act_q <= 1'b0;
      rem_q <= '0;
      ps_q  <= '0;
    end else begin
      if (expired_i && want_irq_i) irq_q <= 1'b1;
      else if (clr_irq_i)          irq_q <= 1'b0;

      if (expired_i && want_rst_i && len_i != '0) begin
        act_q <= 1'b1;
        rem_q <= len_i;
        ps_q  <= '0;
      end else if (act_q) begin
        ps_q <= ps_last ? '0 : ps_q + 1'b1;
        if (ps_last) begin
          if (rem_q == FIELD_W'(1)) begin
            act_q <= 1'b0;
            rem_q <= '0;
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
      end
    end
  end

  assign irq_o = irq_q;
  assign pin_o = act_q ? pol_hi_i : ~pol_hi_i;
  assign oe_o  = push_pull_i | act_q;
endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
  import wdog_pkg::*;
#(
  parameter bit          NEWER_VARIANT = 1'b1,
  parameter int          TICK_DIV      = 24,
  parameter int          ADDR_W        = 8,
  parameter logic [31:0] RESET_RELOAD  = 32'h03EF1480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              expired_o,
  output logic              irq_o,
  output logic              rst_pin_o,
  output logic              rst_oe_o
);
  localparam int FIELD_W = NEWER_VARIANT ? 20 : 8;

  wdog_cmd_t         cmd;
  logic [31:0]       reload_q, width_q, cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              run_q;

  wdog_regfile #(
    .ADDR_W(ADDR_W), .NEWER_VARIANT(NEWER_VARIANT),
    .FIELD_W(FIELD_W), .RESET_RELOAD(RESET_RELOAD)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_i(cnt_q), .rdata(rdata), .reload_o(reload_q),
    .ctrl_o(ctrl_q), .width_o(width_q), .cmd_o(cmd)
  );

  wdog_countdown #(.TICK_DIV(TICK_DIV), .RESET_RELOAD(RESET_RELOAD)) u_cnt (
    .clk(clk), .rst(rst), .cmd_i(cmd), .reload_i(reload_q),
    .slow_i(ctrl_q[CB_SLOW]), .cnt_o(cnt_q), .run_o(run_q),
    .expired_o(expired_o)
  );

  wdog_action #(.TICK_DIV(TICK_DIV), .FIELD_W(FIELD_W)) u_act (
    .clk(clk), .rst(rst), .expired_i(expired_o),
    .want_rst_i(ctrl_q[CB_RST]), .want_irq_i(ctrl_q[CB_IRQ]),
    .clr_irq_i(cmd.clr_irq), .pol_hi_i(width_q[PB_POLHI]),
    .push_pull_i(width_q[PB_PP]), .len_i(width_q[FIELD_W-1:0]),
    .irq_o(irq_o), .pin_o(rst_pin_o), .oe_o(rst_oe_o)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              expired_o,
  input logic              irq_o,
  input logic              rst_pin_o,
  input logic              rst_oe_o,
  input logic [31:0]       cnt_q,
  input logic              run_q,
  input logic [5:0]        ctrl_q,
  input logic [31:0]       width_q
);
  assert_expiry_single_R7: assert property (@(posedge clk) disable iff (rst)
    expired_o |=> !expired_o);

  assert_stop_on_expiry_R7: assert property (@(posedge clk) disable iff (rst)
    expired_o |-> !run_q);

  assert_count_down_only_R6: assert property (@(posedge clk) disable iff (rst)
    (run_q && !wr_en) |=> (cnt_q <= $past(cnt_q)));

  assert_frozen_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_en) |=> $stable(cnt_q));

  assert_ctrl_discard_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[ADDR_W-1:2] == (ADDR_W-2)'(3) && wdata[0] == ctrl_q[0])
      |=> $stable(ctrl_q));

  assert_irq_from_expiry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(expired_o));

  assert_open_drain_level_R10: assert property (@(posedge clk) disable iff (rst)
    (!width_q[30] && rst_oe_o) |-> (rst_pin_o == width_q[31]));

  assert_restart_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[ADDR_W-1:2] == (ADDR_W-2)'(2)) |=> (rdata == 32'd0));
endmodule

bind wdog_keyed_top wdog_keyed_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .expired_o(expired_o), .irq_o(irq_o),
  .rst_pin_o(rst_pin_o), .rst_oe_o(rst_oe_o), .cnt_q(cnt_q),
  .run_q(run_q), .ctrl_q(ctrl_q), .width_q(width_q)
);

// File: tb/tb_wdog_keyed_top.sv
module tb_wdog_keyed_top;
  localparam int TDIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_old;
  logic        expired_o, irq_o, rst_pin_o, rst_oe_o;
  logic        exp_old, irq_old, pin_old, oe_old;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_keyed_top #(.NEWER_VARIANT(1'b1), .TICK_DIV(TDIV)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .expired_o(expired_o), .irq_o(irq_o),
    .rst_pin_o(rst_pin_o), .rst_oe_o(rst_oe_o));

  wdog_keyed_top #(.NEWER_VARIANT(1'b0), .TICK_DIV(TDIV)) dut_old (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_old), .expired_o(exp_old), .irq_o(irq_old),
    .rst_pin_o(pin_old), .rst_oe_o(oe_old));

  // {is_read, req, addr, data, expected}
  localparam int NV = 32;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 4'd1, 8'h00, 32'h0, 32'h03EF1480},          // R1
    {1'b1, 4'd1, 8'h04, 32'h0, 32'h03EF1480},          // R1
    {1'b1, 4'd1, 8'h0C, 32'h0, 32'h0},                 // R1
    {1'b1, 4'd1, 8'h18, 32'h0, 32'h000000FF},          // R1
    {1'b1, 4'd2, 8'h08, 32'h0, 32'h0},                 // R2
    {1'b0, 4'd2, 8'h14, 32'hFFFFFFFF, 32'h0},          // R2
    {1'b1, 4'd2, 8'h14, 32'h0, 32'h0},                 // R2
    {1'b1, 4'd2, 8'h10, 32'h0, 32'h0},                 // R2
    {1'b1, 4'd2, 8'h40, 32'h0, 32'h0},                 // R2
    {1'b0, 4'd2, 8'h00, 32'h12345678, 32'h0},          // R2
    {1'b1, 4'd2, 8'h00, 32'h0, 32'h03EF1480},          // R2
    {1'b0, 4'd3, 8'h04, 32'h10, 32'h0},                // R3
    {1'b1, 4'd3, 8'h04, 32'h0, 32'h10},                // R3
    {1'b1, 4'd3, 8'h00, 32'h0, 32'h03EF1480},          // R3
    {1'b0, 4'd3, 8'h08, 32'h00004756, 32'h0},          // R3
    {1'b1, 4'd3, 8'h00, 32'h0, 32'h03EF1480},          // R3
    {1'b0, 4'd3, 8'h08, 32'hABCD4755, 32'h0},          // R3
    {1'b1, 4'd3, 8'h00, 32'h0, 32'h10},                // R3
    {1'b0, 4'd4, 8'h0C, 32'h3E, 32'h0},                // R4
    {1'b1, 4'd4, 8'h0C, 32'h0, 32'h0},                 // R4
    {1'b0, 4'd10, 8'h18, 32'hA5000123, 32'h0},         // R10
    {1'b1, 4'd10, 8'h18, 32'h0, 32'h80000123},         // R10
    {1'b0, 4'd10, 8'h18, 32'hA8000456, 32'h0},         // R10
    {1'b1, 4'd10, 8'h18, 32'h0, 32'hC0000456},         // R10
    {1'b0, 4'd10, 8'h18, 32'h77000FFF, 32'h0},         // R10
    {1'b1, 4'd10, 8'h18, 32'h0, 32'hC0000FFF},         // R10
    {1'b0, 4'd10, 8'h18, 32'h5A0FFFFF, 32'h0},         // R10
    {1'b1, 4'd10, 8'h18, 32'h0, 32'h400FFFFF},         // R10
    {1'b0, 4'd10, 8'h18, 32'h8A000002, 32'h0},         // R10
    {1'b1, 4'd10, 8'h18, 32'h0, 32'h00000002},         // R10
    {1'b0, 4'd11, 8'h18, 32'h00F00003, 32'h0},         // R11
    {1'b1, 4'd11, 8'h18, 32'h0, 32'h00000003}          // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d_old);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; d_old = rdata_old;
  endtask

  task automatic wait_expiry(output int k);
    k = 0;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (expired_o) begin k = i; break; end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, vo;
    int k, c_act, c_oe, c_hi;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R7 idle expired", {31'd0, expired_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) begin
        rd(VEC[i][71:64], v, vo);
        check($sformatf("R%0d table row %0d", VEC[i][75:72], i), v, VEC[i][31:0]);
      end else begin
        wr(VEC[i][71:64], VEC[i][63:32]);
      end
    end

    // R11: older variant saw the same writes, 8-bit field
    rd(8'h18, v, vo);
    check("R11 older width", vo, 32'h00000003);

    // R6 R7 R8 R9: fast tick, reload 5, irq + reset pulse, open-drain active-low len 3
    wr(8'h04, 32'd5);
    wr(8'h0C, 32'h07);
    wait_expiry(k);
    check("R6 fast expiry cycle", k, 6);
    c_act = 0; c_oe = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0) check("R8 irq raised", {31'd0, irq_o}, 32'd1);
      if (i == 0) check("R7 single pulse", {31'd0, expired_o}, 32'd0);
      if (rst_oe_o) c_oe++;
      if (rst_oe_o && !rst_pin_o) c_act++;
    end
    check("R9 pulse length", c_act, 3 * TDIV);
    check("R10 open-drain oe", c_oe, 3 * TDIV);
    check("R10 idle level", {31'd0, rst_pin_o}, 32'd1);
    rd(8'h00, v, vo);
    check("R7 counter stopped at 0", v, 32'd0);
    check("R8 irq held", {31'd0, irq_o}, 32'd1);

    // R3 R8 R5: restart clears irq and re-arms, then disable freezes
    wr(8'h08, 32'h00004755);
    check("R8 irq cleared by key", {31'd0, irq_o}, 32'd0);
    rd(8'h00, v, vo);
    check("R3 reloaded", v, 32'd5);
    wr(8'h0C, 32'h00);
    rd(8'h00, v, vo);
    check("R5 frozen value", v, 32'd4);
    repeat (10) @(negedge clk);
    rd(8'h00, v, vo);
    check("R5 still frozen", v, 32'd4);
    rd(8'h0C, v, vo);
    check("R5 disable stored", v, 32'd0);

    // R6 slow tick, no actions; active-high push-pull len 1
    wr(8'h18, 32'hA5000001);
    wr(8'h18, 32'hA8000001);
    wr(8'h04, 32'd2);
    wr(8'h0C, 32'h11);
    wait_expiry(k);
    check("R6 slow expiry cycle", k, 3 * TDIV);
    c_hi = 0; c_oe = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rst_pin_o) c_hi++;
      if (rst_oe_o) c_oe++;
    end
    check("R9 no pulse when bit1 clear", c_hi, 0);
    check("R8 no irq when bit2 clear", {31'd0, irq_o}, 32'd0);

    // R4: write keeping enable is dropped
    wr(8'h0C, 32'h13);
    rd(8'h0C, v, vo);
    check("R4 same-enable write dropped", v, 32'h11);
    wr(8'h0C, 32'h02);
    wr(8'h0C, 32'h03);
    wait_expiry(k);
    check("R4 enable rise starts from reload", k, 3);
    c_hi = 0; c_oe = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rst_pin_o) c_hi++;
      if (rst_oe_o) c_oe++;
    end
    check("R10 active-high pulse", c_hi, TDIV);
    check("R10 push-pull oe", c_oe, 20);

    // R3: key re-arms after expiry while enabled
    wr(8'h08, 32'h00004755);
    wait_expiry(k);
    check("R3 re-arm after expiry", k, 3);

    // R11: variants differ on key and field width
    wr(8'h18, 32'hA50001FF);
    rd(8'h18, v, vo);
    check("R11 newer width", v, 32'hC00001FF);
    check("R11 older ignores key", vo, 32'h000000FF);
    wr(8'h18, 32'h5A012345);
    rd(8'h18, v, vo);
    check("R11 newer 20-bit field", v, 32'h40012345);
    check("R11 older 8-bit field", vo, 32'h00000045);

    // R1: reset again
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(8'h0C, v, vo);
    check("R1 ctrl after reset", v, 32'd0);
    rd(8'h18, v, vo);
    check("R1 width after reset", v, 32'h000000FF);
    rd(8'h00, v, vo);
    check("R1 status after reset", v, 32'h03EF1480);
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule